// File: doc/BRIEF.md
# Masked Comma Word Aligner

This block recovers the 10-bit code-group boundary of a received stream that arrives as unaligned 10-bit parallel words. Every cycle it looks at a window made of the word that arrived one cycle earlier and the word arriving now. It compares each of the ten possible 10-bit slices of that window against two programmable comma patterns. One pattern normally covers each running-disparity form of the comma, and a shared per-bit mask decides which bit positions count. When realignment is permitted and a slice matches, the block locks onto that offset. It then emits code groups cut at the locked offset until realignment is permitted again.

A two-bit mode input picks one of three behaviours. Bypass passes the stream through untouched and searches for nothing. User mode lets a software enable gate realignment. Automatic mode leaves realignment to a request from an external link synchronization machine. The patterns and the mask are meant to be driven from a group-wide source, and the mode is set for each channel. Alongside the aligned word, the block reports whether that word is a comma and whether a boundary has been locked.

Top module: `comma_word_aligner`

## Requirements
- R1: While rst_n is low, aligned_data is 0, comma_det is 0 and aligned is 0, and the locked offset is 0.
- R2: With mode 0 (bypass) or mode 3 (treated as bypass), aligned_data equals rx_data from two clock edges earlier. comma_det and aligned read 0, and the locked offset returns to 0.
- R3: The window in a cycle is {rx_data[8:0], previous rx_data}, with the previous word in the low 10 bits. Bit 0 is the earliest received bit, and the order from bit 9 to bit 0 is j h g f i e d c b a. The slice at offset k (0 to 9) is window bits k+9..k. aligned_data, updated at the next edge, is the slice at the selected offset.
- R4: A slice matches when, for every bit where cmp_mask is 1, it equals pat_pos or it equals pat_neg. Bits where cmp_mask is 0 are ignored.
- R5: When several offsets match in one window, the lowest offset is taken.
- R6: When realignment is permitted and some offset matches, that offset is locked and also used for the output cut from that same window. aligned reads 1 after that edge and stays 1 until bypass or reset.
- R7: When realignment is not permitted, the locked offset is held, even if other offsets match.
- R8: In mode 1 (user), realignment is permitted exactly when sw_align_en is 1. lsm_realign has no effect.
- R9: In mode 2 (automatic), realignment is permitted exactly when lsm_realign is 1. sw_align_en has no effect.
- R10: Outside bypass, comma_det is 1 in the same cycle that aligned_data holds a word matching either pattern under the mask, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_data | input | 10 | Unaligned received word, bit 0 earliest |
| pat_pos | input | 10 | First comma pattern (positive disparity form) |
| pat_neg | input | 10 | Second comma pattern (negative disparity form) |
| cmp_mask | input | 10 | Per-bit compare mask, 1 = compared |
| mode | input | 2 | 0 bypass, 1 user, 2 automatic, 3 bypass |
| sw_align_en | input | 1 | Software realignment enable (user mode) |
| lsm_realign | input | 1 | Realignment request from link synchronization machine (automatic mode) |
| aligned_data | output | 10 | Code group cut at the selected offset |
| comma_det | output | 1 | aligned_data is a masked comma match |
| aligned | output | 1 | A boundary has been locked |

## Verification
Two functions can fall in the same cycle: capturing a new offset and emitting a word through the output multiplexer. The word cut from the capturing window must already use the new offset, and comma_det must rise with it. The bench provokes this by slipping the bit stream by a few bits while realignment is gated off, then opening the gate. The bench also drives constant words in which several offsets match at once. A behavioural bit-level model predicts the word, the comma flag and the aligned flag on every edge, and these are compared with the outputs at each falling edge. Directed counts confirm that shifted commas never appear while the offset is held.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_USER   = 2'd1,
    MODE_AUTO   = 2'd2,
    MODE_RSVD   = 2'd3
  } align_mode_e;

  // Both bypass and the unused code pass data straight through.
  function automatic logic mode_is_bypass(input logic [1:0] m);
    return (m == MODE_BYPASS) || (m == MODE_RSVD);
  endfunction

  // Gate that lets a new boundary be taken.
  function automatic logic realign_permitted(input logic [1:0] m,
                                             input logic sw_en,
                                             input logic lsm_req);
    logic ok;
    case (m)
      MODE_USER: ok = sw_en;
      MODE_AUTO: ok = lsm_req;
      default:   ok = 1'b0;
    endcase
    return ok;
  endfunction

endpackage

// File: rtl/cwa_history.sv
module cwa_history #(
  parameter int unsigned W = 10,
  localparam int unsigned WINW = 2 * W - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [W-1:0]    cur_word,
  output logic [W-1:0]    prev_word,
  output logic [WINW-1:0] window
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_word <= '0;
    else        prev_word <= cur_word;
  end

  // Top bit of the current word never lands in any slice.
  assign window = {cur_word[W-2:0], prev_word};

endmodule

// File: rtl/cwa_search.sv
module cwa_search #(
  parameter int unsigned W = 10,
  localparam int unsigned WINW = 2 * W - 1,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic [WINW-1:0]       window,
  input  logic [W-1:0]          pat_a,
  input  logic [W-1:0]          pat_b,
  input  logic [W-1:0]          mask,
  output logic [W-1:0][W-1:0]   cand,
  output logic [W-1:0]          hit_vec,
  output logic                  hit,
  output logic [OFFW-1:0]       hit_off
);

  function automatic logic masked_eq(input logic [W-1:0] word,
                                     input logic [W-1:0] pat,
                                     input logic [W-1:0] msk);
    return ((word ^ pat) & msk) == '0;
  endfunction

  for (genvar k = 0; k < W; k++) begin : g_slice
    assign cand[k]    = window[k +: W];
    assign hit_vec[k] = masked_eq(cand[k], pat_a, mask) |
                        masked_eq(cand[k], pat_b, mask);
  end

  // Lowest matching offset wins: scan from the top down.
  always_comb begin
    hit     = 1'b0;
    hit_off = '0;
    for (int k = W - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        hit     = 1'b1;
        hit_off = OFFW'(k);
      end
    end
  end

endmodule

// File: rtl/cwa_lock.sv
module cwa_lock
  import cwa_pkg::*;
#(
  parameter int unsigned W = 10,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      mode,
  input  logic            sw_align_en,
  input  logic            lsm_realign,
  input  logic            hit,
  input  logic [OFFW-1:0] hit_off,
  output logic            bypass,
  output logic            allow,
  output logic            capture,
  output logic [OFFW-1:0] locked_off,
  output logic [OFFW-1:0] sel_off,
  output logic            aligned_q
);

  assign bypass  = mode_is_bypass(mode);
  assign allow   = realign_permitted(mode, sw_align_en, lsm_realign);
  assign capture = allow & hit;

  // The capturing window already uses the new offset.
  assign sel_off = bypass  ? '0      :
                   capture ? hit_off : locked_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_off <= '0;
      aligned_q  <= 1'b0;
    end else if (bypass) begin
      locked_off <= '0;
      aligned_q  <= 1'b0;
    end else if (capture) begin
      locked_off <= hit_off;
      aligned_q  <= 1'b1;
    end
  end

endmodule

// File: rtl/cwa_emit.sv
module cwa_emit #(
  parameter int unsigned W = 10,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [W-1:0][W-1:0] cand,
  input  logic [OFFW-1:0]     sel_off,
  input  logic                bypass,
  input  logic [W-1:0]        pat_a,
  input  logic [W-1:0]        pat_b,
  input  logic [W-1:0]        mask,
  output logic [W-1:0]        data_q,
  output logic                comma_q
);

  function automatic logic masked_eq(input logic [W-1:0] word,
                                     input logic [W-1:0] pat,
                                     input logic [W-1:0] msk);
    return ((word ^ pat) & msk) == '0;
  endfunction

  logic [W-1:0] pick;
  logic         pick_is_comma;

  assign pick          = cand[sel_off];
  assign pick_is_comma = !bypass && (masked_eq(pick, pat_a, mask) ||
                                     masked_eq(pick, pat_b, mask));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      comma_q <= 1'b0;
    end else begin
      data_q  <= pick;
      comma_q <= pick_is_comma;
    end
  end

endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import cwa_pkg::*;
#(
  parameter int unsigned W = 10,
  localparam int unsigned WINW = 2 * W - 1,
  localparam int unsigned OFFW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rx_data,
  input  logic [W-1:0] pat_pos,
  input  logic [W-1:0] pat_neg,
  input  logic [W-1:0] cmp_mask,
  input  logic [1:0]   mode,
  input  logic         sw_align_en,
  input  logic         lsm_realign,
  output logic [W-1:0] aligned_data,
  output logic         comma_det,
  output logic         aligned
);

  // Named internal events, visible to the bound checker.
  logic [W-1:0]          prev_word;
  logic [WINW-1:0]       window;
  logic [W-1:0][W-1:0]   cand;
  logic [W-1:0]          hit_vec;
  logic                  any_hit;
  logic [OFFW-1:0]       hit_off;
  logic                  in_bypass;
  logic                  realign_ok;
  logic                  capture_evt;
  logic [OFFW-1:0]       locked_off;
  logic [OFFW-1:0]       sel_off;

  cwa_history #(.W(W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .cur_word  (rx_data),
    .prev_word (prev_word),
    .window    (window)
  );

  cwa_search #(.W(W)) u_search (
    .window  (window),
    .pat_a   (pat_pos),
    .pat_b   (pat_neg),
    .mask    (cmp_mask),
    .cand    (cand),
    .hit_vec (hit_vec),
    .hit     (any_hit),
    .hit_off (hit_off)
  );

  cwa_lock #(.W(W)) u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .sw_align_en (sw_align_en),
    .lsm_realign (lsm_realign),
    .hit         (any_hit),
    .hit_off     (hit_off),
    .bypass      (in_bypass),
    .allow       (realign_ok),
    .capture     (capture_evt),
    .locked_off  (locked_off),
    .sel_off     (sel_off),
    .aligned_q   (aligned)
  );

  cwa_emit #(.W(W)) u_emit (
    .clk     (clk),
    .rst_n   (rst_n),
    .cand    (cand),
    .sel_off (sel_off),
    .bypass  (in_bypass),
    .pat_a   (pat_pos),
    .pat_b   (pat_neg),
    .mask    (cmp_mask),
    .data_q  (aligned_data),
    .comma_q (comma_det)
  );

endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
  parameter int unsigned W = 10,
  localparam int unsigned OFFW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic [W-1:0]    rx_data,
  input logic [W-1:0]    pat_pos,
  input logic [W-1:0]    pat_neg,
  input logic [W-1:0]    cmp_mask,
  input logic [1:0]      mode,
  input logic            sw_align_en,
  input logic            lsm_realign,
  input logic [W-1:0]    aligned_data,
  input logic            comma_det,
  input logic            aligned,
  input logic            capture_evt,
  input logic [OFFW-1:0] locked_off
);

  logic [1:0] since_rst;
  logic       byp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  assign byp = (mode == 2'd0) || (mode == 2'd3);

  // R2: pass-through with two edges of delay
  p_bypass_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && $past(byp)) |-> aligned_data == $past(rx_data, 2));

  // R2: flags quiet after a bypass cycle
  p_bypass_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && $past(byp)) |-> (!comma_det && !aligned));

  // R7: offset held while realignment is closed
  p_hold_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!byp && !capture_evt) |=> $stable(locked_off));

  // R6: a capture raises the aligned flag
  p_capture_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_evt && !byp) |=> aligned);

  // R8: user mode gated by the software enable only
  p_user_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && !sw_align_en) |-> !capture_evt);

  // R9: automatic mode gated by the link request only
  p_auto_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !lsm_realign) |-> !capture_evt);

  // R10: a flagged word really matches a pattern
  p_comma_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd1 && comma_det) |->
      ((((aligned_data ^ $past(pat_pos)) & $past(cmp_mask)) == '0) ||
       (((aligned_data ^ $past(pat_neg)) & $past(cmp_mask)) == '0)));

endmodule

bind comma_word_aligner cwa_checker #(.W(W)) u_cwa_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_data      (rx_data),
  .pat_pos      (pat_pos),
  .pat_neg      (pat_neg),
  .cmp_mask     (cmp_mask),
  .mode         (mode),
  .sw_align_en  (sw_align_en),
  .lsm_realign  (lsm_realign),
  .aligned_data (aligned_data),
  .comma_det    (comma_det),
  .aligned      (aligned),
  .capture_evt  (capture_evt),
  .locked_off   (locked_off)
);

// File: tb/test_comma_word_aligner.sv
module test_comma_word_aligner;

  localparam logic [9:0] KP = 10'h283;  // comma, positive disparity form
  localparam logic [9:0] KN = 10'h17C;  // comma, negative disparity form

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] rx_data = '0, pat_pos = '0, pat_neg = '0, cmp_mask = '0;
  logic [1:0] mode = 2'd0;
  logic       sw_align_en = 1'b0, lsm_realign = 1'b0;
  logic [9:0] aligned_data;
  logic       comma_det, aligned;

  always #10 clk = ~clk;

  comma_word_aligner i_comma_word_aligner (
    .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .pat_pos(pat_pos),
    .pat_neg(pat_neg), .cmp_mask(cmp_mask), .mode(mode),
    .sw_align_en(sw_align_en), .lsm_realign(lsm_realign),
    .aligned_data(aligned_data), .comma_det(comma_det), .aligned(aligned)
  );

  int total = 0, bad = 0;
  bit done = 1'b0, cmp_on = 1'b0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- behavioural reference, bit by bit ----
  function automatic logic [9:0] take(input logic [19:0] w, input int k);
    logic [9:0] r;
    for (int b = 0; b < 10; b++) r[b] = w[k + b];
    return r;
  endfunction

  function automatic bit fits(input logic [9:0] c, input logic [9:0] p,
                              input logic [9:0] m);
    for (int b = 0; b < 10; b++) if (m[b] && c[b] != p[b]) return 1'b0;
    return 1'b1;
  endfunction

  logic [9:0] m_prev, m_out;
  int         m_off;
  bit         m_comma, m_alg;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_prev = '0; m_out = '0; m_off = 0; m_comma = 0; m_alg = 0;
    end else begin
      automatic logic [19:0] win = {rx_data, m_prev};
      automatic int found = -1;
      automatic bit byp = (mode == 2'd0) || (mode == 2'd3);
      automatic bit ok = (mode == 2'd1 && sw_align_en) || (mode == 2'd2 && lsm_realign);
      for (int k = 0; k < 10; k++)
        if (found < 0 && (fits(take(win, k), pat_pos, cmp_mask) ||
                          fits(take(win, k), pat_neg, cmp_mask))) found = k;
      if (byp) begin
        m_off = 0; m_out = m_prev; m_comma = 0; m_alg = 0;
      end else begin
        if (ok && found >= 0) begin m_off = found; m_alg = 1; end
        m_out   = take(win, m_off);
        m_comma = fits(m_out, pat_pos, cmp_mask) || fits(m_out, pat_neg, cmp_mask);
      end
      m_prev = rx_data;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on && !done) begin
      chk(aligned_data == m_out, (mode == 0 || mode == 3) ? "R2 data" : "R3 data",
          32'(aligned_data), 32'(m_out));
      chk(comma_det == m_comma, "R10 comma flag", 32'(comma_det), 32'(m_comma));
      chk(aligned == m_alg, "R6 aligned flag", 32'(aligned), 32'(m_alg));
    end
  end

  // ---- serial stream generator ----
  bit sq[$];
  int sym_n = 0;
  bit alt_bit = 1'b0;
  bit use_stream = 1'b0;

  task automatic slip(input int n);
    for (int i = 0; i < n; i++) begin sq.push_back(alt_bit); alt_bit = ~alt_bit; end
  endtask

  task automatic next_word();
    logic [9:0] s, w;
    s = (sym_n % 5 == 0) ? (((sym_n / 5) % 2) ? KN : KP) : 10'h2AA;
    sym_n++;
    for (int b = 0; b < 10; b++) sq.push_back(s[b]);
    for (int b = 0; b < 10; b++) w[b] = sq.pop_front();
    rx_data = w;
  endtask

  task automatic cyc();
    @(negedge clk);
    if (use_stream) next_word();
  endtask

  int n_comma, n_badc, n_k, n_al;
  task automatic run(input int n);
    n_comma = 0; n_badc = 0; n_k = 0; n_al = 0;
    for (int i = 0; i < n; i++) begin
      cyc();
      if (comma_det) begin
        n_comma++;
        if (aligned_data != KP && aligned_data != KN) n_badc++;
      end
      if (aligned_data == KP || aligned_data == KN) n_k++;
      if (aligned) n_al++;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) cyc();
    chk(aligned_data == 0 && !comma_det && !aligned, "R1 reset outputs",
        {aligned_data, comma_det, aligned}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;

    // R2 bypass latency of two edges
    mode = 2'd0;
    cyc(); rx_data = 10'h3A5;
    cyc(); rx_data = 10'h000;
    cyc();
    chk(aligned_data == 10'h3A5, "R2 bypass delay", 32'(aligned_data), 32'h3A5);

    // typical comma set: low seven bits compared
    pat_pos = 10'h003; pat_neg = 10'h07C; cmp_mask = 10'h07F;
    use_stream = 1'b1;
    slip(3);
    run(40);
    chk(n_comma == 0 && n_al == 0, "R2 bypass no search", n_comma + n_al, 0);
    mode = 2'd3;
    run(20);
    chk(n_comma == 0 && n_al == 0, "R2 mode3 bypass", n_comma + n_al, 0);

    // R8 user mode, enable open
    mode = 2'd1; sw_align_en = 1'b1;
    run(40);
    chk(aligned == 1'b1, "R6 locks after comma", 32'(aligned), 1);
    chk(n_k > 0, "R8 user mode aligns", n_k, 1);
    chk(n_comma > 0 && n_badc == 0, "R10 flag with comma word", n_badc, 0);

    // R7 enable closed, stream slips: offset must hold
    sw_align_en = 1'b0;
    slip(4);
    run(3);
    run(40);
    chk(n_k == 0 && n_comma == 0, "R7 hold on slip", n_k + n_comma, 0);
    chk(aligned == 1'b1, "R6 aligned kept while held", 32'(aligned), 1);

    // R8 link request ignored in user mode
    lsm_realign = 1'b1;
    run(30);
    chk(n_k == 0, "R8 lsm ignored in user mode", n_k, 0);

    // R9 automatic mode
    mode = 2'd2; lsm_realign = 1'b0; sw_align_en = 1'b1;
    run(30);
    chk(n_k == 0, "R9 sw enable ignored in auto", n_k, 0);
    lsm_realign = 1'b1;
    run(40);
    chk(n_k > 0, "R9 auto realigns on request", n_k, 1);

    // R4 masked bits ignored: wrong upper bits, low seven compared
    pat_pos = 10'h383; pat_neg = 10'h3FC;
    slip(2);
    run(3);
    run(40);
    chk(n_k > 0, "R4 masked-off bits ignored", n_k, 1);
    // R4 full mask: upper bits now count, no match anywhere
    cmp_mask = 10'h3FF;
    slip(3);
    run(3);
    run(40);
    chk(n_k == 0 && n_comma == 0, "R4 full mask rejects", n_k + n_comma, 0);

    // R5 priority with direct words
    use_stream = 1'b0;
    mode = 2'd1; sw_align_en = 1'b1; lsm_realign = 1'b0;
    pat_pos = 10'h001; pat_neg = 10'h001; cmp_mask = 10'h001;
    rx_data = 10'h024;
    repeat (3) cyc();
    chk(aligned_data == 10'h009, "R5 lowest offset", 32'(aligned_data), 32'h009);
    chk(comma_det == 1'b1, "R10 flag on priority word", 32'(comma_det), 1);

    // R3 offset nine reaches into current word
    rx_data = 10'h200;
    repeat (3) cyc();
    chk(aligned_data == 10'h001, "R3 offset nine slice", 32'(aligned_data), 32'h001);

    // R7 hold offset nine with other matches present
    sw_align_en = 1'b0;
    rx_data = 10'h024;
    repeat (3) cyc();
    chk(aligned_data == 10'h048, "R7 held offset", 32'(aligned_data), 32'h048);
    chk(comma_det == 1'b0, "R10 no flag off pattern", 32'(comma_det), 0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule